// File: doc/BRIEF.md
# Dual-Bank Register File with Shared ALU Flags

This block is the data slice of a small 8-bit execution core. It keeps two banks of sixteen 8-bit general registers, only one of which is visible at a time, and an ALU that combines a register with either a second register or an 8-bit immediate. The result goes back into the first register, and one set of status flags (zero, carry, interrupt enable) is updated. Both banks share that flag set. A bank-select command swaps the visible bank, so an interrupt handler can work in its own registers without saving the interrupted code's registers first.

An instruction decoder outside the block drives the opcode, the two register indices, the immediate, the operand-select bit, the bank command and the write enable once per cycle. The ALU result is shown combinationally on `result_o` in the same cycle. The register write, the flag update and the bank change all take effect at the next rising clock edge. Reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_ni` rises.

Top module: `bra_core`

## Requirements
- R1: After reset, bank A is visible, zero_o, carry_o and irq_en_o are 0, and every register of both banks reads 0.
- R2: The two banks are separate storage of sixteen 8-bit registers each. A write to index n in one bank leaves index n of the other bank unchanged.
- R3: bank_cmd_i = 2'b01 selects bank A and 2'b10 selects bank B. 2'b00 and 2'b11 keep the current bank. The bank command acts whatever the value of we_i. The new bank applies from the next clock edge, so reads and the write in the cycle that carries the command still use the previous bank.
- R4: Operand A is register dst_idx_i of the visible bank. Operand B is imm_i when use_imm_i = 1 and register src_idx_i of the visible bank when use_imm_i = 0.
- R5: Opcodes are 0 copy (result = B), 1 AND, 2 OR, 3 XOR, 4 add, 5 add with carry, 6 subtract (A-B), 7 subtract with borrow. The result is taken modulo 256 and appears on result_o in the same cycle. With we_i = 1 it is written to register dst_idx_i at the clock edge.
- R6: For opcodes 1 to 7 with we_i = 1, zero_o becomes 1 when the 8-bit result is 0 and 0 otherwise. Opcode 0 leaves all flags unchanged.
- R7: For add and add with carry, carry_o becomes 1 when the full sum exceeds 255. For subtract and subtract with borrow, carry_o becomes 1 when the full difference is below 0. Add with carry adds the incoming carry_o, and subtract with borrow subtracts it.
- R8: AND, OR and XOR with we_i = 1 clear carry_o.
- R9: Opcode 8 sets irq_en_o and opcode 9 clears it. Opcodes 8 to 15 show 0 on result_o, write no register and leave zero_o and carry_o unchanged. Opcodes 10 to 15 also leave irq_en_o unchanged.
- R10: With we_i = 0, no register and no flag changes, and result_o still shows the combinational result.
- R11: The flags are not banked. A bank change leaves them as they were, and add with carry after a bank change uses the carry left by the operation before the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| op_i | input | 4 | ALU opcode |
| dst_idx_i | input | 4 | Index of operand A and of the register written |
| src_idx_i | input | 4 | Index of the operand B register |
| imm_i | input | 8 | Immediate operand B |
| use_imm_i | input | 1 | 1 selects imm_i as operand B |
| bank_cmd_i | input | 2 | Bank command: 01 bank A, 10 bank B, others keep |
| we_i | input | 1 | Commit result and flags at the clock edge |
| result_o | output | 8 | Combinational ALU result |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |
| irq_en_o | output | 1 | Interrupt-enable flag |

## Verification
The assertions check on every cycle that the flags do not move without a write enable, that logical operations clear carry, that the zero flag follows the committed result, that the add carry matches the operands, that the interrupt-enable opcodes act, and that the bank register holds or switches as commanded. Only the bench's scenarios can show that data stays separate between the banks, that the command cycle still uses the old bank, that carry passes across a bank switch into add with carry, and that reset clears every register of both banks. All of these need a value written in one cycle and read back several cycles later through the ports.

// File: rtl/bra_pkg.sv
package bra_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned REG_NUM = 16;
  localparam int unsigned IDX_W   = $clog2(REG_NUM);
  localparam int unsigned BANKS   = 2;
  localparam int unsigned OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OPC_COPY = 4'd0,
    OPC_AND  = 4'd1,
    OPC_OR   = 4'd2,
    OPC_XOR  = 4'd3,
    OPC_ADD  = 4'd4,
    OPC_ADDC = 4'd5,
    OPC_SUB  = 4'd6,
    OPC_SUBB = 4'd7,
    OPC_IEN  = 4'd8,
    OPC_IDIS = 4'd9
  } opc_e;

  typedef enum logic [1:0] {
    BSEL_KEEP  = 2'b00,
    BSEL_A     = 2'b01,
    BSEL_B     = 2'b10,
    BSEL_KEEP2 = 2'b11
  } bsel_e;
endpackage

// File: rtl/bra_rst_sync.sv
module bra_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/bra_regfile.sv
module bra_regfile #(
  parameter int unsigned DATA_W  = bra_pkg::DATA_W,
  parameter int unsigned REG_NUM = bra_pkg::REG_NUM,
  localparam int unsigned IDX_W  = $clog2(REG_NUM),
  localparam int unsigned BANKS  = bra_pkg::BANKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bank_cmd_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  import bra_pkg::*;

  logic              bank_q, bank_d;
  logic [DATA_W-1:0] regs_q [BANKS][REG_NUM];
  logic              wen    [BANKS][REG_NUM];
  logic [DATA_W-1:0] bank_rd_a [BANKS];
  logic [DATA_W-1:0] bank_rd_b [BANKS];

  // bank select: next state
  always_comb begin
    bank_d = bank_q;
    case (bsel_e'(bank_cmd_i))
      BSEL_A:  bank_d = 1'b0;
      BSEL_B:  bank_d = 1'b1;
      default: bank_d = bank_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= 1'b0;
    else         bank_q <= bank_d;
  end

  // per-entry write enables, decoded against the bank visible this cycle
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      for (int r = 0; r < REG_NUM; r++) begin
        wen[b][r] = wr_en_i && (bank_q == b[0]) && (wr_idx_i == r[IDX_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < REG_NUM; r++)
          regs_q[b][r] <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < REG_NUM; r++)
          if (wen[b][r]) regs_q[b][r] <= wr_data_i;
    end
  end

  // one read mux pair per bank, then the bank pick
  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank_rd
    assign bank_rd_a[gb] = regs_q[gb][rd_a_idx_i];
    assign bank_rd_b[gb] = regs_q[gb][rd_b_idx_i];
  end

  assign rd_a_o = bank_rd_a[bank_q];
  assign rd_b_o = bank_rd_b[bank_q];

  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_cmd_i == BSEL_KEEP || bank_cmd_i == BSEL_KEEP2) |=> $stable(bank_q));

  p_bank_to_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_cmd_i == BSEL_B) |=> (bank_q == 1'b1));

  p_bank_to_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_cmd_i == BSEL_A) |=> (bank_q == 1'b0));
endmodule

// File: rtl/bra_alu.sv
module bra_alu #(
  parameter int unsigned DATA_W = bra_pkg::DATA_W,
  localparam int unsigned OP_W  = bra_pkg::OP_W
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              upd_zc_o,
  output logic              wr_reg_o,
  output logic              ie_set_o,
  output logic              ie_clr_o
);
  import bra_pkg::*;

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] dif_w;
  logic            cin_add;
  logic            cin_sub;

  always_comb begin
    cin_add = (op_i == OPC_ADDC) ? carry_i : 1'b0;
    cin_sub = (op_i == OPC_SUBB) ? carry_i : 1'b0;
    sum_w   = {1'b0, opa_i} + {1'b0, opb_i} + {{DATA_W{1'b0}}, cin_add};
    dif_w   = {1'b0, opa_i} - {1'b0, opb_i} - {{DATA_W{1'b0}}, cin_sub};
  end

  always_comb begin
    res_o    = '0;
    carry_o  = carry_i;
    upd_zc_o = 1'b0;
    wr_reg_o = 1'b0;
    ie_set_o = 1'b0;
    ie_clr_o = 1'b0;
    case (op_i)
      OPC_COPY: begin
        res_o    = opb_i;
        wr_reg_o = 1'b1;
      end
      OPC_AND, OPC_OR, OPC_XOR: begin
        res_o    = (op_i == OPC_AND) ? (opa_i & opb_i) :
                   (op_i == OPC_OR)  ? (opa_i | opb_i) : (opa_i ^ opb_i);
        carry_o  = 1'b0;
        upd_zc_o = 1'b1;
        wr_reg_o = 1'b1;
      end
      OPC_ADD, OPC_ADDC: begin
        res_o    = sum_w[DATA_W-1:0];
        carry_o  = sum_w[DATA_W];
        upd_zc_o = 1'b1;
        wr_reg_o = 1'b1;
      end
      OPC_SUB, OPC_SUBB: begin
        res_o    = dif_w[DATA_W-1:0];
        carry_o  = dif_w[DATA_W];
        upd_zc_o = 1'b1;
        wr_reg_o = 1'b1;
      end
      OPC_IEN:  ie_set_o = 1'b1;
      OPC_IDIS: ie_clr_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/bra_flags.sv
module bra_flags #(
  parameter int unsigned DATA_W = bra_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              upd_zc_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  output logic              zero_o,
  output logic              carry_o,
  output logic              ie_o
);
  logic zero_q, zero_d;
  logic carry_q, carry_d;
  logic ie_q, ie_d;
  logic zc_en, ie_en;

  always_comb begin
    zc_en   = commit_i && upd_zc_i;
    ie_en   = commit_i && (ie_set_i || ie_clr_i);
    zero_d  = (res_i == '0);
    carry_d = carry_i;
    ie_d    = ie_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (zc_en) begin
      zero_q  <= zero_d;
      carry_q <= carry_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end

  assign zero_o  = zero_q;
  assign carry_o = carry_q;
  assign ie_o    = ie_q;

  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable({zero_q, carry_q, ie_q}));
endmodule

// File: rtl/bra_core.sv
module bra_core #(
  parameter int unsigned DATA_W  = bra_pkg::DATA_W,
  parameter int unsigned REG_NUM = bra_pkg::REG_NUM,
  localparam int unsigned IDX_W  = $clog2(REG_NUM),
  localparam int unsigned OP_W   = bra_pkg::OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [IDX_W-1:0]  src_idx_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              use_imm_i,
  input  logic [1:0]        bank_cmd_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              irq_en_o
);
  import bra_pkg::*;

  logic              rst_n_s;
  logic [DATA_W-1:0] reg_a, reg_b, opb;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c, upd_zc, wr_reg, ie_set, ie_clr;

  bra_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n_s)
  );

  bra_regfile #(.DATA_W(DATA_W), .REG_NUM(REG_NUM)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .bank_cmd_i(bank_cmd_i),
    .rd_a_idx_i(dst_idx_i),
    .rd_b_idx_i(src_idx_i),
    .rd_a_o    (reg_a),
    .rd_b_o    (reg_b),
    .wr_en_i   (we_i && wr_reg),
    .wr_idx_i  (dst_idx_i),
    .wr_data_i (alu_res)
  );

  assign opb = use_imm_i ? imm_i : reg_b;

  bra_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (op_i),
    .opa_i   (reg_a),
    .opb_i   (opb),
    .carry_i (carry_o),
    .res_o   (alu_res),
    .carry_o (alu_c),
    .upd_zc_o(upd_zc),
    .wr_reg_o(wr_reg),
    .ie_set_o(ie_set),
    .ie_clr_o(ie_clr)
  );

  bra_flags #(.DATA_W(DATA_W)) u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .commit_i(we_i),
    .upd_zc_i(upd_zc),
    .res_i   (alu_res),
    .carry_i (alu_c),
    .ie_set_i(ie_set),
    .ie_clr_i(ie_clr),
    .zero_o  (zero_o),
    .carry_o (carry_o),
    .ie_o    (irq_en_o)
  );

  assign result_o = alu_res;

  p_logic_clears_c_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (we_i && (op_i == OPC_AND || op_i == OPC_OR || op_i == OPC_XOR)) |=> !carry_o);

  p_zero_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (we_i && op_i >= OPC_AND && op_i <= OPC_SUBB) |=> (zero_o == ($past(result_o) == '0)));

  p_add_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (we_i && op_i == OPC_ADD) |=>
      (carry_o == ((({1'b0, $past(reg_a)}) + ({1'b0, $past(opb)})) > (DATA_W+1)'(2**DATA_W - 1))));

  p_ie_set_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (we_i && op_i == OPC_IEN) |=> irq_en_o);

  p_ie_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (we_i && op_i == OPC_IDIS) |=> !irq_en_o);

  p_copy_keeps_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (op_i == OPC_COPY) |=> $stable({zero_o, carry_o}));
endmodule

// File: tb/tb_bra_core.sv
module tb_bra_core;
  logic       clk;
  logic       rst_n;
  logic [3:0] op, dst, src;
  logic [7:0] imm;
  logic       use_imm, we;
  logic [1:0] bcmd;
  logic [7:0] result;
  logic       zf, cf, ief;

  int unsigned n_chk;
  int unsigned n_bad;
  bit          done;

  bra_core dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .dst_idx_i(dst), .src_idx_i(src),
    .imm_i(imm), .use_imm_i(use_imm), .bank_cmd_i(bcmd), .we_i(we),
    .result_o(result), .zero_o(zf), .carry_o(cf), .irq_en_o(ief)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0] cmd;
    logic [3:0] op;
    logic [3:0] dst;
    logic [3:0] src;
    logic       ui;
    logic [7:0] imm;
    logic       we;
    logic [7:0] er;
    logic       ez;
    logic       ec;
    logic       ei;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{2'd0, 4'd0, 4'd1, 4'd0, 1'b1, 8'h9C, 1'b1, 8'h9C, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd0, 4'd2, 4'd0, 1'b1, 8'h75, 1'b1, 8'h75, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd4, 4'd1, 4'd2, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd5, 4'd2, 4'd0, 1'b1, 8'h8A, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    '{2'd0, 4'd7, 4'd1, 4'd0, 1'b1, 8'h10, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},
    '{2'd0, 4'd6, 4'd1, 4'd0, 1'b1, 8'h01, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd1, 4'd1, 4'd0, 1'b1, 8'h0F, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd3, 4'd1, 4'd0, 1'b1, 8'h0F, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},
    '{2'd0, 4'd2, 4'd2, 4'd0, 1'b1, 8'hA0, 1'b1, 8'hA0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 4'd0, 4'd1, 4'd0, 1'b1, 8'h33, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd0, 4'd3, 4'd1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd6, 4'd3, 4'd0, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},
    '{2'd0, 4'd4, 4'd4, 4'd0, 1'b1, 8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd4, 4'd4, 4'd0, 1'b1, 8'h01, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    '{2'd1, 4'd7, 4'd5, 4'd0, 1'b1, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd0, 4'd6, 4'd1, 1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd4, 4'd1, 4'd0, 1'b1, 8'hCD, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd0, 4'd7, 4'd1, 1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd8, 4'd0, 4'd0, 1'b1, 8'h55, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1},
    '{2'd2, 4'd9, 4'd0, 4'd0, 1'b1, 8'h55, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd0, 4'd0, 4'd5, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd15, 4'd5, 4'd0, 1'b1, 8'h77, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd5, 4'd5, 4'd0, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    '{2'd3, 4'd0, 4'd8, 4'd1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0},
    '{2'd0, 4'd0, 4'd9, 4'd1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0}
  };
  // Vector notes: 0-8 R4 R5 R6 R7 R8; 9 R3 (write lands in old bank A);
  // 10-13 R2 (bank B empty); 14 R7 R11; 15-17 R10; 18-21 R9; 22 R11; 23-24 R3.

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; checks result mid-cycle, flags after the next rising edge
  task automatic step(input logic [1:0] c, input logic [3:0] o, input logic [3:0] d,
                      input logic [3:0] s, input logic u, input logic [7:0] i,
                      input logic w, input int er, input string tag);
    bcmd = c; op = o; dst = d; src = s; use_imm = u; imm = i; we = w;
    #1;
    if (er >= 0) chk({tag, " result"}, int'(result), er);
    @(negedge clk);
  endtask

  task automatic check_flags(input int ez, input int ec, input int ei, input string tag);
    chk({tag, " zero"}, int'(zf), ez);
    chk({tag, " carry"}, int'(cf), ec);
    chk({tag, " irq_en"}, int'(ief), ei);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bcmd = 2'd0; op = 4'd0; dst = 4'd0; src = 4'd0; use_imm = 1'b0; imm = 8'd0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    do_reset();

    // R1: reset state, both banks read zero, flags clear
    check_flags(0, 0, 0, "R1 after reset");
    for (int r = 0; r < 16; r++) step(2'd0, 4'd0, 4'd0, r[3:0], 1'b0, 8'h00, 1'b0, 0, "R1 bank A reg");
    step(2'd2, 4'd0, 4'd0, 4'd0, 1'b1, 8'h00, 1'b0, -1, "R1 switch");
    for (int r = 0; r < 16; r++) step(2'd0, 4'd0, 4'd0, r[3:0], 1'b0, 8'h00, 1'b0, 0, "R1 bank B reg");
    step(2'd1, 4'd0, 4'd0, 4'd0, 1'b1, 8'h00, 1'b0, -1, "R1 back to A");
    check_flags(0, 0, 0, "R1 after sweep");

    // table walk
    for (int k = 0; k < NV; k++) begin
      step(VT[k].cmd, VT[k].op, VT[k].dst, VT[k].src, VT[k].ui, VT[k].imm, VT[k].we,
           int'(VT[k].er), $sformatf("R5 vec%0d", k));
      check_flags(int'(VT[k].ez), int'(VT[k].ec), int'(VT[k].ei), $sformatf("R6/R7 vec%0d", k));
    end

    // R1: reset in mid-run clears registers, flags and returns to bank A
    do_reset();
    check_flags(0, 0, 0, "R1 mid-run reset");
    step(2'd0, 4'd0, 4'd0, 4'd6, 1'b0, 8'h00, 1'b0, 0, "R1 bank A s6 cleared");
    step(2'd0, 4'd0, 4'd1, 4'd0, 1'b1, 8'h5A, 1'b1, 8'h5A, "R1 write in default bank");
    // R3: command cycle still reads old bank, next cycle sees new bank
    step(2'd2, 4'd0, 4'd0, 4'd1, 1'b0, 8'h00, 1'b0, 8'h5A, "R3 same-cycle read old bank");
    step(2'd0, 4'd0, 4'd0, 4'd1, 1'b0, 8'h00, 1'b0, 8'h00, "R3 bank B after switch");
    // R2: write bank B s1, bank A s1 keeps its value
    step(2'd0, 4'd0, 4'd1, 4'd0, 1'b1, 8'hC3, 1'b1, 8'hC3, "R2 write B s1");
    step(2'd1, 4'd0, 4'd0, 4'd1, 1'b0, 8'h00, 1'b0, 8'hC3, "R2 read B s1 in switch cycle");
    step(2'd0, 4'd0, 4'd0, 4'd1, 1'b0, 8'h00, 1'b0, 8'h5A, "R2 bank A s1 untouched");
    // R4: immediate versus register operand with the same index fields
    step(2'd0, 4'd2, 4'd1, 4'd1, 1'b1, 8'h81, 1'b0, 8'hDB, "R4 immediate operand");
    step(2'd0, 4'd3, 4'd1, 4'd1, 1'b0, 8'h81, 1'b0, 8'h00, "R4 register operand");
    check_flags(0, 0, 0, "R10 no commit keeps flags");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule